// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Guard Register

This block keeps the status byte of a small serial EEPROM and decides whether a write may proceed. The serial front end sends it one-cycle strobes once a command has been decoded: enable write, disable write, a status-write load carrying the received byte, and a commit pulse when chip select rises. The write sequencer sends a pulse that drops the enable latch when an internal write ends. The block also watches the active-low write-protect pin and the busy flag, and it answers address queries with a permit flag.

Two protect bits fence off part of the array. The fenced part is the upper quarter, the upper half or the whole address space. A write needs the enable latch set, the protect pin high and the device idle. An array write also needs an address outside the fenced range. The status byte is read back in this form: `{4'b1111, bp[1:0], wel, busy}`. The write latch (wel) and the protect bits are registered. The busy bit follows the input directly. The permit flags are combinational.

Top module: `eeprom_status_guard`

## Requirements
- R1: After reset the status byte reads 8'hF0 while busy is low: protect bits 00 and latch clear.
- R2: Status bits 7..4 always read 1. Bit 0 follows `busy` in the same cycle. Bits 3:2 hold the protect bits and bit 1 holds the latch.
- R3: `wren_stb` sets the latch in the next cycle and `wrdi_stb` clears it. When both arrive together, clear wins.
- R4: `wel_clr` clears the latch in the next cycle, even while busy, and overrides both strobes.
- R5: While `busy` is high, `wren_stb`, `wrdi_stb` and `wrsr_stb` have no effect.
- R6: `wrsr_stb` is taken only when `status_wr_ok` is 1. It stores only `wrsr_data[3:2]` as pending protect bits. A later `commit_stb` with `wp_n` high copies those two bits into status bits 3:2. No other status bit follows the data.
- R7: While a status write is pending, a cycle with `wp_n` low cancels it, and a later commit changes nothing. A commit without a pending write has no effect. A commit in the same cycle as `wrsr_stb` discards the strobe. After the commit, `wp_n` cannot undo the new protect bits.
- R8: `status_wr_ok` equals latch AND `wp_n` AND NOT `busy`.
- R9: `array_wr_ok` is `status_wr_ok` AND the queried address is unprotected. The protect bits select the fenced range: 00 fences nothing; 01 fences addresses whose two top bits are 11 (0x180–0x1FF for 9 bits); 10 fences addresses with the top bit set (0x100–0x1FF); 11 fences every address.
- R10: A query that hits a fenced address changes no state. The latch and the protect bits read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wren_stb | input | 1 | Write-enable command decoded |
| wrdi_stb | input | 1 | Write-disable command decoded |
| wel_clr | input | 1 | End-of-write pulse that clears the latch |
| wrsr_stb | input | 1 | Status-write byte received |
| wrsr_data | input | 8 | Byte received with the status write |
| commit_stb | input | 1 | Chip select rose, so the pending status write starts |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write in progress |
| qry_addr | input | AW | Array address to check |
| status | output | 8 | Status byte |
| status_wr_ok | output | 1 | A status write would be accepted |
| array_wr_ok | output | 1 | An array write to `qry_addr` would be accepted |

## Verification
The hardest case to reach is a cancelled status write. A load is accepted only with the latch set and the device idle. The protect pin then has to fall before the commit, and the commit has to arrive later with the pin high again. That commit must leave the old protect bits in place. Directed sequences build this chain explicitly, including the variant where the pin drops only after the commit. A long random run, with a low rate of protect-pin drops and frequent commits, reaches further mixes of pending, cancelled and committed writes. During that run every permit flag is compared against the decoded range for the current protect bits.

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wren_stb,
  input  logic          wrdi_stb,
  input  logic          wel_clr,
  input  logic          wrsr_stb,
  input  logic [7:0]    wrsr_data,
  input  logic          commit_stb,
  input  logic          wp_n,
  input  logic          busy,
  input  logic [AW-1:0] qry_addr,
  output logic [7:0]    status,
  output logic          status_wr_ok,
  output logic          array_wr_ok
);

  logic       wel;
  logic [1:0] bp;
  logic       pend;
  logic [1:0] pend_bp;
  logic [1:0] top;
  logic       fenced;

  assign top = qry_addr[AW-1 -: 2];

  always_comb begin
    case (bp)
      2'b00:   fenced = 1'b0;
      2'b01:   fenced = (top == 2'b11);
      2'b10:   fenced = top[1];
      default: fenced = 1'b1;
    endcase
  end

  assign status       = {4'hF, bp, wel, busy};
  assign status_wr_ok = wel & wp_n & ~busy;
  assign array_wr_ok  = status_wr_ok & ~fenced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      bp      <= 2'b00;
      pend    <= 1'b0;
      pend_bp <= 2'b00;
    end else begin
      if (wel_clr)
        wel <= 1'b0;
      else if (!busy && wrdi_stb)
        wel <= 1'b0;
      else if (!busy && wren_stb)
        wel <= 1'b1;

      if (!wp_n)
        pend <= 1'b0;
      else if (commit_stb)
        pend <= 1'b0;
      else if (wrsr_stb && status_wr_ok) begin
        pend    <= 1'b1;
        pend_bp <= wrsr_data[3:2];
      end

      if (commit_stb && pend && wp_n)
        bp <= pend_bp;
    end
  end

endmodule

module eeprom_status_guard_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wren_stb,
  input logic          wrdi_stb,
  input logic          wel_clr,
  input logic          commit_stb,
  input logic          wp_n,
  input logic          busy,
  input logic [AW-1:0] qry_addr,
  input logic [7:0]    status,
  input logic          status_wr_ok,
  input logic          array_wr_ok
);

  p_wren_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_stb && !wrdi_stb && !wel_clr && !busy) |=> status[1]);

  p_wrdi_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrdi_stb && !busy) |=> !status[1]);

  p_end_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !status[1]);

  p_busy_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !status[1]) |=> !status[1]);

  p_bp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_stb |=> $stable(status[3:2]));

  p_pin_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> (!status_wr_ok && !array_wr_ok));

  p_full_fence_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !array_wr_ok);

  p_array_implies_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr_ok |-> status_wr_ok);

endmodule

bind eeprom_status_guard eeprom_status_guard_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
  .wel_clr(wel_clr), .commit_stb(commit_stb), .wp_n(wp_n), .busy(busy),
  .qry_addr(qry_addr), .status(status), .status_wr_ok(status_wr_ok),
  .array_wr_ok(array_wr_ok)
);

// File: tb/eeprom_status_guard_tb_top.sv
`timescale 1ns/1ps
module eeprom_status_guard_tb_top;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren_stb = 0, wrdi_stb = 0, wel_clr = 0, wrsr_stb = 0, commit_stb = 0;
  logic [7:0] wrsr_data = 0;
  logic wp_n = 1, busy = 0;
  logic [AW-1:0] qry_addr = 0;
  logic [7:0] status;
  logic status_wr_ok, array_wr_ok;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic m_wel = 0, m_pend = 0;
  logic [1:0] m_bp = 0, m_pbp = 0;

  always #10 clk = ~clk;

  eeprom_status_guard #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .wel_clr(wel_clr), .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data),
    .commit_stb(commit_stb), .wp_n(wp_n), .busy(busy), .qry_addr(qry_addr),
    .status(status), .status_wr_ok(status_wr_ok), .array_wr_ok(array_wr_ok));

  function automatic logic fenced(input logic [1:0] b, input logic [AW-1:0] a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1] & a[AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic dis, input logic clr, input logic ld,
                      input logic [7:0] d, input logic cm, input logic wp,
                      input logic bz, input logic [AW-1:0] a);
    logic sok;
    @(negedge clk);
    wren_stb = en; wrdi_stb = dis; wel_clr = clr; wrsr_stb = ld; wrsr_data = d;
    commit_stb = cm; wp_n = wp; busy = bz; qry_addr = a;
    #1;
    sok = m_wel & wp & ~bz;
    check("R2 status", status, {4'hF, m_bp, m_wel, bz});
    check("R8 status_wr_ok", status_wr_ok, sok);
    check("R9 array_wr_ok", array_wr_ok, sok & ~fenced(m_bp, a));
    if (cm && m_pend && wp) m_bp = m_pbp;
    if (!wp) m_pend = 0;
    else if (cm) m_pend = 0;
    else if (ld && sok) begin m_pend = 1; m_pbp = d[3:2]; end
    if (clr) m_wel = 0;
    else if (!bz && dis) m_wel = 0;
    else if (!bz && en) m_wel = 1;
  endtask

  task automatic idle(input logic [AW-1:0] a);
    step(0, 0, 0, 0, 8'h00, 0, 1, 0, a);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(0);
    check("R1 reset status", status, 8'hF0);
    check("R1 reset permit", status_wr_ok, 0);

    step(1, 0, 0, 0, 0, 0, 1, 0, 0);
    idle(0);
    check("R3 wren sets latch", status[1], 1);

    step(1, 1, 0, 0, 0, 0, 1, 0, 0);
    idle(0);
    check("R3 clear wins", status[1], 0);

    step(1, 0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 8'h35, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    idle(9'h17F);
    check("R6 only bits 3:2 taken", status, 8'hF6);
    check("R9 below quarter fence", array_wr_ok, 1);
    idle(9'h180);
    check("R9 inside quarter fence", array_wr_ok, 0);
    check("R10 latch kept after fenced query", status[1], 1);

    step(0, 0, 0, 1, 8'h08, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    idle(0);
    check("R7 cancelled write keeps bits", status[3:2], 2'b01);

    step(0, 0, 0, 1, 8'h08, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(9'h0FF);
    check("R7 committed bits survive pin drop", status[3:2], 2'b10);
    check("R9 half fence low side", array_wr_ok, 1);

    step(0, 1, 0, 1, 8'h0C, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1, 1, 0);
    idle(0);
    check("R5 busy ignores wrdi", status[1], 1);
    check("R5 busy ignores wrsr", status[3:2], 2'b10);

    step(0, 0, 1, 0, 0, 0, 1, 1, 0);
    idle(0);
    check("R4 end pulse clears latch while busy", status[1], 0);

    step(0, 0, 0, 1, 8'h0C, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    idle(0);
    check("R6 load refused without latch", status[3:2], 2'b10);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 100) < 15, ($urandom % 100) < 8, ($urandom % 100) < 4,
           ($urandom % 100) < 20, 8'($urandom), ($urandom % 100) < 15,
           ($urandom % 100) < 88, ($urandom % 100) < 25, AW'($urandom));
    end

    done = 1;
    summary();
  end
endmodule